// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block produces the interrupt status for a synchronous serial port that has a transmit FIFO and a receive FIFO. It tracks the occupancy of both FIFOs with push and pop strobes. From that occupancy, a receive idle timer and the receive strobe, it derives four raw interrupt conditions. Two of them are level conditions on the fill of the FIFOs. Two are sticky flags: a receive overrun, and a receive timeout that fires when stored data sits unserviced.

A small register port lets software write an enable mask, read the raw and the masked status, and write ones to a clear register. The clear register drops the sticky flags. A single interrupt line carries the registered OR of the masked bits. Serial shifting, bit clocks and frame formats belong to the surrounding port and are not part of this block.

Top module: `sio_irq_stat`

## Requirements
- R1: After reset, the raw status at offset 0x18 reads 0x8 (only bit 3 set). The mask at 0x14 reads 0, the masked status at 0x1C reads 0 and irq is 0.
- R2: Raw bit 3 is 1 exactly when the transmit occupancy is at most DEPTH/2. A transmit push while the FIFO is full, and a transmit pop while it is empty, leave the occupancy unchanged.
- R3: Raw bit 2 is 1 exactly when the receive occupancy is at least DEPTH/2. A receive pop while the FIFO is empty is ignored.
- R4: A receive push while the receive FIFO holds DEPTH entries, with no receive pop in the same cycle, sets raw bit 0 (overrun). The occupancy stays at DEPTH because the new frame overwrites the newest entry. A push and a pop together on a full FIFO do not set bit 0.
- R5: Raw bit 1 (timeout) sets on the tmo_limit-th consecutive clock in which the receive FIFO is non-empty and sees neither push nor pop. It sets only once per idle stretch, and a tmo_limit of 0 disables it.
- R6: A receive push clears raw bit 1.
- R7: Writing the clear register at 0x20 clears the timeout flag when bit 1 of the written data is 1, and clears the overrun flag when bit 0 is 1. Zero bits, and bits 3:2, have no effect. Reading 0x20 returns 0.
- R8: When a flag's set event and a clear write for that flag fall in the same cycle, the flag ends up set.
- R9: The mask register at 0x14 holds bits 3:0 and can be read back. The masked status at 0x1C equals raw AND mask. Writes to 0x18 and 0x1C change nothing.
- R10: irq equals the OR of the four masked bits, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | A word is written into the transmit FIFO |
| tx_pop | input | 1 | The shifter takes a word from the transmit FIFO |
| rx_push | input | 1 | A complete frame was received |
| rx_pop | input | 1 | Software reads a word from the receive FIFO |
| tmo_limit | input | TMO_W | Idle cycles before a receive timeout; 0 disables it |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a flag being set and software clearing that same flag. The bench provokes this by writing the clear register on every cycle of an idle stretch, so that one of those writes meets the cycle in which the timeout fires. It then repeats the pattern with a clear write issued together with an overflowing receive push. The flag must read 1 afterwards and must drop on the next clear that has no set event beside it.

The second pair is a push and a pop on a full receive FIFO in the same cycle. This must neither raise the overrun flag nor change the occupancy.

All of these are judged against a behavioural model that is compared with every register and with irq after each clock.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
   localparam int OFF_MASK  = 'h14;
   localparam int OFF_RAW   = 'h18;
   localparam int OFF_MIS   = 'h1C;
   localparam int OFF_CLR   = 'h20;
   localparam int NUM_SRC   = 4;
   localparam int B_TXHALF  = 3;
   localparam int B_RXHALF  = 2;
   localparam int B_TMO     = 1;
   localparam int B_OVR     = 0;

   typedef struct packed {
      logic tx_half;
      logic rx_half;
      logic tmo;
      logic ovr;
   } irq_src_t;
endpackage

// File: rtl/sio_occ_cnt.sv
module sio_occ_cnt #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [CW-1:0] level,
   output logic          full,
   output logic          push_lost
);
   logic pop_ok, push_ok;

   assign full      = (level == CW'(DEPTH));
   assign pop_ok    = pop && (level != '0);
   assign push_ok   = push && (!full || pop_ok);
   // a push that found no room: the caller decides what that means
   assign push_lost = push && full && !pop_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= '0;
      else begin
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sio_rx_idle.sv
module sio_rx_idle #(
   parameter int TMO_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             activity,
   input  logic             nonempty,
   input  logic [TMO_W-1:0] limit,
   output logic             fire
);
   logic [TMO_W-1:0] idle_q;

   // fires on the edge that completes the limit-th idle cycle; the counter
   // then parks at the limit, so one stretch gives one event
   assign fire = (limit != '0) && nonempty && !activity
                 && (idle_q == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_q <= '0;
      else if (activity || !nonempty)
         idle_q <= '0;
      else if (idle_q < limit)
         idle_q <= idle_q + 1'b1;
   end
endmodule

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
   import sio_irq_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_half,
   input  logic          rx_half,
   input  logic          tmo_set,
   input  logic          tmo_drop,
   input  logic          ovr_set,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output irq_src_t      raw,
   output logic [NUM_SRC-1:0] mask,
   output logic          irq
);
   logic tmo_q, ovr_q;
   logic sel_mask, sel_raw, sel_mis, sel_clr;
   logic [NUM_SRC-1:0] masked;

   assign sel_mask = (reg_addr == AW'(OFF_MASK));
   assign sel_raw  = (reg_addr == AW'(OFF_RAW));
   assign sel_mis  = (reg_addr == AW'(OFF_MIS));
   assign sel_clr  = (reg_addr == AW'(OFF_CLR));

   assign raw.tx_half = tx_half;
   assign raw.rx_half = rx_half;
   assign raw.tmo     = tmo_q;
   assign raw.ovr     = ovr_q;

   // sticky flags: a set event outranks any clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (tmo_set)
            tmo_q <= 1'b1;
         else if (tmo_drop || (reg_wr && sel_clr && reg_wdata[B_TMO]))
            tmo_q <= 1'b0;
         if (ovr_set)
            ovr_q <= 1'b1;
         else if (reg_wr && sel_clr && reg_wdata[B_OVR])
            ovr_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask <= '0;
      else if (reg_wr && sel_mask)
         mask <= reg_wdata[NUM_SRC-1:0];
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign masked[i] = raw[i] & mask[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else
         irq <= |masked;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_mask)
         reg_rdata[NUM_SRC-1:0] = mask;
      else if (sel_raw)
         reg_rdata[NUM_SRC-1:0] = raw;
      else if (sel_mis)
         reg_rdata[NUM_SRC-1:0] = masked;
   end
endmodule

// File: rtl/sio_irq_stat.sv
module sio_irq_stat
   import sio_irq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int TMO_W = 12,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_push,
   input  logic             tx_pop,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             reg_wr,
   input  logic [AW-1:0]    reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             irq
);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int HALF = DEPTH / 2;

   if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("sio_irq_stat: DEPTH must be even and at least 2");
   end
   if (AW < 6) begin : g_bad_aw
      $error("sio_irq_stat: AW must reach offset 0x20");
   end
   if (DW < NUM_SRC) begin : g_bad_dw
      $error("sio_irq_stat: DW narrower than the status vector");
   end
   if (TMO_W < 1) begin : g_bad_tw
      $error("sio_irq_stat: TMO_W must be positive");
   end

   logic [CW-1:0] tx_level, rx_level;
   logic          tx_full, rx_full;
   logic          tx_lost, rx_lost;
   logic          tmo_fire;
   irq_src_t      raw_w;
   logic [NUM_SRC-1:0] mask_w;

   sio_occ_cnt #(.DEPTH(DEPTH)) u_tx_occ (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
      .level(tx_level), .full(tx_full), .push_lost(tx_lost)
   );

   sio_occ_cnt #(.DEPTH(DEPTH)) u_rx_occ (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
      .level(rx_level), .full(rx_full), .push_lost(rx_lost)
   );

   sio_rx_idle #(.TMO_W(TMO_W)) u_idle (
      .clk(clk), .rst_n(rst_n),
      .activity(rx_push || rx_pop),
      .nonempty(rx_level != '0),
      .limit(tmo_limit),
      .fire(tmo_fire)
   );

   sio_irq_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .tx_half(tx_level <= CW'(HALF)),
      .rx_half(rx_level >= CW'(HALF)),
      .tmo_set(tmo_fire),
      .tmo_drop(rx_push),
      .ovr_set(rx_lost),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .raw(raw_w), .mask(mask_w), .irq(irq)
   );

   logic unused_ok;
   assign unused_ok = &{1'b0, tx_full, rx_full, tx_lost};
endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk #(
   parameter int DEPTH = 8,
   parameter int CW    = 4,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_push,
   input logic          rx_pop,
   input logic          reg_wr,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic [CW-1:0] rx_level,
   input logic [3:0]    raw,
   input logic [3:0]    mask,
   input logic          irq
);
   logic clr_hit, mask_hit, ovr_evt;
   assign clr_hit  = reg_wr && (reg_addr == AW'('h20));
   assign mask_hit = reg_wr && (reg_addr == AW'('h14));
   assign ovr_evt  = rx_push && !rx_pop && (rx_level == CW'(DEPTH));

   // R3 occupancy never passes the depth
   a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= CW'(DEPTH));

   // R4 overrun sets and the FIFO stays full
   a_r4_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> (raw[0] && rx_level == CW'(DEPTH)));

   // R6 new receive data drops the timeout
   a_r6_tmo_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !raw[1]);

   // R7 write-one clears overrun when no set competes
   a_r7_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && reg_wdata[0] && !ovr_evt) |=> !raw[0]);

   // R7 overrun is sticky without a clear
   a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[0] && !(clr_hit && reg_wdata[0])) |=> raw[0]);

   // R8 set beats clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_evt && clr_hit && reg_wdata[0]) |=> raw[0]);

   // R9 mask holds unless written
   a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_hit |=> $stable(mask));

   // R10 irq follows the masked OR one clock later
   a_r10_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw & mask)) |=> irq);
   a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw & mask)) |=> !irq);
endmodule

bind sio_irq_stat sio_irq_chk #(.DEPTH(DEPTH), .CW(CW), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .rx_level(rx_level), .raw(raw_w), .mask(mask_w), .irq(irq)
);

// File: tb/tb_sio_irq_stat.sv
`timescale 1ns/1ps
module tb_sio_irq_stat;
   localparam int D  = 8;
   localparam int TW = 12;
   localparam int AW = 8;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          tx_push, tx_pop, rx_push, rx_pop, reg_wr;
   logic [TW-1:0] tmo_limit;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata, reg_rdata;
   logic          irq;

   sio_irq_stat #(.DEPTH(D), .TMO_W(TW), .AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_pop(rx_pop), .tmo_limit(tmo_limit),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // stimulus for the next edge
   bit  s_tp, s_tpo, s_rp, s_rpo, s_wr;
   int  s_addr, s_data, s_lim;
   // reference state
   int  m_tx, m_rx, m_idle, m_tmo, m_ovr, m_mask, m_irq;
   int  n_cmp, n_bad;
   string req;

   function automatic int m_raw();
      return ((m_tx <= D/2) ? 8 : 0) | ((m_rx >= D/2) ? 4 : 0)
             | (m_tmo << 1) | m_ovr;
   endfunction

   task automatic check(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_edge();
      int rw, pv, pu, ov, fire, clrw;
      rw   = m_raw();
      m_irq_next_calc: begin end
      pv   = (s_tpo && m_tx > 0) ? 1 : 0;
      pu   = (s_tp && (m_tx < D || pv == 1)) ? 1 : 0;
      m_tx = m_tx + pu - pv;
      ov   = (s_rp && m_rx == D && !s_rpo) ? 1 : 0;
      fire = (s_lim != 0 && m_rx != 0 && !s_rp && !s_rpo && m_idle == s_lim - 1) ? 1 : 0;
      if (s_rp || s_rpo || m_rx == 0) m_idle = 0;
      else if (m_idle < s_lim) m_idle = m_idle + 1;
      pv   = (s_rpo && m_rx > 0) ? 1 : 0;
      pu   = (s_rp && (m_rx < D || pv == 1)) ? 1 : 0;
      m_rx = m_rx + pu - pv;
      clrw = (s_wr && s_addr == 'h20) ? 1 : 0;
      if (fire == 1) m_tmo = 1;
      else if (s_rp || (clrw == 1 && s_data[1])) m_tmo = 0;
      if (ov == 1) m_ovr = 1;
      else if (clrw == 1 && s_data[0]) m_ovr = 0;
      m_irq = ((rw & m_mask) != 0) ? 1 : 0;
      if (s_wr && s_addr == 'h14) m_mask = s_data & 'hF;
   endtask

   task automatic compare();
      reg_wr = 1'b0;
      reg_addr = AW'('h14); #0.2; check("mask", int'(reg_rdata), m_mask);
      reg_addr = AW'('h18); #0.2; check("raw", int'(reg_rdata), m_raw());
      reg_addr = AW'('h1C); #0.2; check("masked", int'(reg_rdata), m_raw() & m_mask);
      reg_addr = AW'('h20); #0.2; check("clr-read", int'(reg_rdata), 0);
      check("irq", int'(irq), m_irq);
   endtask

   task automatic tick();
      tx_push = s_tp; tx_pop = s_tpo; rx_push = s_rp; rx_pop = s_rpo;
      reg_wr = s_wr; reg_addr = AW'(s_addr); reg_wdata = DW'(s_data);
      tmo_limit = TW'(s_lim);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic quiet();
      s_tp = 0; s_tpo = 0; s_rp = 0; s_rpo = 0; s_wr = 0; s_addr = 0; s_data = 0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr_reg(int a, int d);
      quiet(); s_wr = 1; s_addr = a; s_data = d; tick(); quiet();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      n_cmp = 0; n_bad = 0; s_lim = 0; quiet();
      m_tx = 0; m_rx = 0; m_idle = 0; m_tmo = 0; m_ovr = 0; m_mask = 0; m_irq = 0;
      rst_n = 1'b0;
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; reg_wr = 0;
      reg_addr = '0; reg_wdata = '0; tmo_limit = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      req = "R1"; compare();
      check("R1 raw value", int'(m_raw()), 8);

      // R2: transmit threshold, push on full, pop on empty
      req = "R2";
      quiet(); s_tpo = 1; tick();
      quiet(); s_tp = 1; ticks(D + 2);
      quiet(); s_tp = 1; s_tpo = 1; tick();
      quiet(); s_tpo = 1; ticks(D + 1);

      // R9: mask programming, ignored writes to status offsets
      req = "R9";
      wr_reg('h14, 'hF);
      wr_reg('h18, 'hFF);
      wr_reg('h1C, 'h0);
      wr_reg('h14, 'h5);
      // R10: mask switching toggles irq
      req = "R10";
      wr_reg('h14, 'h8); ticks(2);
      wr_reg('h14, 'h0); ticks(2);
      wr_reg('h14, 'hF);

      // R3: receive threshold and empty pop
      req = "R3";
      quiet(); s_rpo = 1; tick();
      quiet(); s_rp = 1; ticks(D);

      // R4: overrun, and push+pop on a full FIFO without overrun
      req = "R4";
      quiet(); s_rp = 1; s_rpo = 1; tick();
      quiet(); s_rp = 1; tick();
      check("R4 overrun flag", int'(m_ovr), 1);
      // R7: zero bits and bits 3:2 have no effect, then bit 0 clears
      req = "R7";
      wr_reg('h20, 'hC);
      wr_reg('h20, 'h1);
      // R8: overrun set together with its clear
      req = "R8";
      quiet(); s_rp = 1; s_wr = 1; s_addr = 'h20; s_data = 'h1; tick();
      check("R8 ovr after set+clear", int'(m_ovr), 1);
      wr_reg('h20, 'h1);

      // R5: timeout with limit 5
      req = "R5";
      quiet(); s_rpo = 1; ticks(3);
      quiet(); s_lim = 5; ticks(12);
      check("R5 timeout fired", int'(m_tmo), 1);
      // R6: a receive push drops it
      req = "R6";
      quiet(); s_lim = 5; s_rp = 1; tick();
      quiet(); s_lim = 5; ticks(3);
      // R8: clear written on every idle cycle, meeting the set
      req = "R8";
      quiet(); s_lim = 5; s_wr = 1; s_addr = 'h20; s_data = 'h2; ticks(8);
      quiet(); s_lim = 5; s_rp = 1; tick();
      quiet(); s_lim = 5; s_wr = 1; s_addr = 'h20; s_data = 'h2; ticks(4);
      quiet(); s_lim = 5; tick();
      check("R8 tmo after set+clear", int'(m_tmo), 1);
      // R7: timeout cleared via bit 1
      req = "R7";
      s_lim = 5; wr_reg('h20, 'h2);
      // R5: limit 0 disables
      req = "R5";
      quiet(); s_lim = 0; ticks(40);
      check("R5 disabled", int'(m_tmo), 0);

      // mixed random traffic
      req = "R10";
      for (int i = 0; i < 3000; i++) begin
         int pick;
         s_tp  = ($urandom_range(0, 99) < 30);
         s_tpo = ($urandom_range(0, 99) < 30);
         s_rp  = ($urandom_range(0, 99) < 20);
         s_rpo = ($urandom_range(0, 99) < 15);
         s_wr  = ($urandom_range(0, 99) < 20);
         pick  = $urandom_range(0, 4);
         s_addr = (pick == 0) ? 'h14 : (pick == 1) ? 'h18 : (pick == 2) ? 'h1C :
                  (pick == 3) ? 'h20 : 'h00;
         s_data = $urandom_range(0, 255);
         s_lim  = 4;
         if (i % 200 > 150) begin s_rp = 0; s_rpo = 0; end
         tick();
      end

      summary();
      $finish;
   end
endmodule